// File: doc/BRIEF.md
# ADC Conversion Sequencer with Shadowed Channel Selection

This block is the digital controller of a successive-approximation converter. It counts conversion time in half periods of the converter clock: its own clock `clk` runs at twice the converter rate, and it drives the converter clock phase out on `adc_clk`. It supports three kinds of conversion. A single conversion is started by a CPU write. An auto-triggered conversion is started by a rising edge on an external trigger. Free-running conversions restart by themselves at every completion.

The CPU may write a channel/reference selection at any time. The value goes into a holding register. It is copied into the active selection that the analog front end sees only while that copy cannot disturb sampling. For each conversion the block issues a sample-and-hold strobe, a result-latch strobe and a sticky completion flag. When a trigger starts a conversion, it also issues a one-cycle prescaler-reset pulse. The converter clock is realigned to the trigger at the same moment.

Top module: `adc_conv_seq`

## Requirements
- R1: During and right after reset, all outputs are 0: `adc_clk`, `sel_active`, `busy`, `sample_hold`, `result_latch`, `done_flag`, `psc_rst` and `first_pend`.
- R2: While no conversion runs, a value written with `sel_wr` appears on `sel_active` two `clk` edges after the write: one edge to load the holding register, one to copy it.
- R3: From the launch of a conversion, `sel_active` holds its value up to and including the third-last half-cycle of that conversion, whatever is written meanwhile.
- R4: Copying resumes in the final converter cycle. In the last two half-cycles (count at or above length minus 2), `sel_active` follows the holding register again.
- R5: A `start_wr` pulse seen while idle launches a conversion at the next rising converter-clock edge. `busy` first reads 1 in a cycle where `adc_clk` is 1. `adc_clk` toggles on every `clk` edge while `en` is 1 and no trigger launches.
- R6: The first conversion after `en` rises lasts 50 half-cycles. `sample_hold` is high at half-cycle 27 (counting from 0 at launch) and `result_latch` at half-cycle 49.
- R7: A normal conversion lasts 31 half-cycles, with `sample_hold` at half-cycle 7 and `result_latch` at half-cycle 30.
- R8: With `auto_en`=1 and `free_run`=0, a rising edge on `trig` while idle launches a conversion of 32 half-cycles. `sample_hold` is at half-cycle 8 and `result_latch` at 31. `psc_rst` is high only in the launch cycle, and `adc_clk` is forced to 1 in that cycle.
- R9: With `auto_en`=1 and `free_run`=1, the cycle after `result_latch` is half-cycle 0 of a new conversion with the R8 timing, and no new start write is needed.
- R10: `done_flag` is set by the edge that ends the `result_latch` cycle. It stays set until a `flag_clr` cycle clears it. Setting wins over clearing in the same cycle.
- R11: A trigger edge or a start write that arrives while `busy` is 1 is ignored. The running conversion keeps its length, and no conversion follows it.
- R12: `first_pend` rises on the edge after `en` rises and falls together with the first completion. While it is 1, any launch except a free-running restart uses the R6 timing.
- R13: With `en` at 0, the next cycle shows `busy`=0 and `adc_clk`=0, and any pending start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the converter clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| sel_wr | input | 1 | Write strobe for the selection holding register |
| sel_data | input | SEL_W | Channel/reference selection value |
| start_wr | input | 1 | CPU start write (single conversion or first free-running one) |
| auto_en | input | 1 | Auto-trigger enable |
| free_run | input | 1 | With auto_en, restart at each completion |
| trig | input | 1 | External trigger, rising edge active |
| flag_clr | input | 1 | Write-one-to-clear of the completion flag |
| adc_clk | output | 1 | Converter clock phase |
| sel_active | output | SEL_W | Selection presented to the analog front end |
| busy | output | 1 | Conversion in progress |
| sample_hold | output | 1 | Sample-and-hold strobe |
| result_latch | output | 1 | Result-latch strobe, last half-cycle |
| done_flag | output | 1 | Sticky completion flag |
| psc_rst | output | 1 | Prescaler-reset pulse on trigger launch |
| first_pend | output | 1 | Next launch uses first-conversion timing |

## Verification
The bench builds the block with its default parameters: a 5-bit selection and half-cycle lengths of 50/31/32 with sample points 27/7/8. This puts every conversion kind, both lock boundaries and the free-running handover within a few hundred cycles. A random phase then mixes selection writes, stray starts and triggers during busy, flag clears and enable drops against a cycle-level reference model. These drops abort conversions mid-flight and re-arm the first-conversion timing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    CK_NORM  = 2'd0,
    CK_AUTO  = 2'd1,
    CK_FIRST = 2'd2
  } conv_kind_e;
endpackage

// File: rtl/adc_phase_ctl.sv
module adc_phase_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trig,
  input  logic trig_mode,
  input  logic busy,
  output logic ph,
  output logic trig_go,
  output logic psc_rst,
  output logic en_rise
);
  logic ph_d, trig_q, en_q, psc_d;

  assign en_rise = en && !en_q;
  assign trig_go = en && trig_mode && trig && !trig_q && !busy;

  always_comb begin
    ph_d = ph;
    if (!en)          ph_d = 1'b0;
    else if (trig_go) ph_d = 1'b1;
    else              ph_d = ~ph;
    psc_d = trig_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      trig_q  <= 1'b0;
      en_q    <= 1'b0;
      psc_rst <= 1'b0;
    end else begin
      ph      <= ph_d;
      trig_q  <= trig;
      en_q    <= en;
      psc_rst <= psc_d;
    end
  end

  // R5: free toggling of the converter phase when no trigger realigns it
  a_r5_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !trig_go) |=> (ph != $past(ph)));
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int FIRST_HALF = 50,
  parameter int FIRST_SH   = 27,
  parameter int NORM_HALF  = 31,
  parameter int NORM_SH    = 7,
  parameter int AUTO_HALF  = 32,
  parameter int AUTO_SH    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cpu_go,
  input  logic trig_go,
  input  logic free_mode,
  input  logic first_pend,
  output logic busy,
  output logic sample,
  output logic last,
  output logic unlock,
  output logic done_evt
);
  localparam int MAXH = (FIRST_HALF > NORM_HALF) ?
                        ((FIRST_HALF > AUTO_HALF) ? FIRST_HALF : AUTO_HALF) :
                        ((NORM_HALF > AUTO_HALF) ? NORM_HALF : AUTO_HALF);
  localparam int CW = $clog2(MAXH + 1);

  logic [CW-1:0] cnt, cnt_d, len_q, len_d, sh_q, sh_d;
  logic          busy_d, fr_go, launch;
  conv_kind_e    kind;

  assign last     = busy && (cnt == len_q - CW'(1));
  assign sample   = busy && (cnt == sh_q);
  assign unlock   = !busy || (cnt >= len_q - CW'(2));
  assign done_evt = last && en;
  assign fr_go    = last && free_mode;
  assign launch   = cpu_go || trig_go || fr_go;

  always_comb begin
    if (fr_go)           kind = CK_AUTO;
    else if (first_pend) kind = CK_FIRST;
    else if (trig_go)    kind = CK_AUTO;
    else                 kind = CK_NORM;
  end

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt;
    len_d  = len_q;
    sh_d   = sh_q;
    if (!en) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (launch) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      case (kind)
        CK_FIRST: begin len_d = CW'(FIRST_HALF); sh_d = CW'(FIRST_SH); end
        CK_AUTO:  begin len_d = CW'(AUTO_HALF);  sh_d = CW'(AUTO_SH);  end
        default:  begin len_d = CW'(NORM_HALF);  sh_d = CW'(NORM_SH);  end
      endcase
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy) begin
      cnt_d  = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      len_q <= CW'(NORM_HALF);
      sh_q  <= CW'(NORM_SH);
    end else begin
      busy  <= busy_d;
      cnt   <= cnt_d;
      len_q <= len_d;
      sh_q  <= sh_d;
    end
  end

  // R6: the half-cycle count never reaches the programmed length
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < len_q));
  // R11: a running conversion advances by one and is never restarted early
  a_r11_busy_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy && !last) |=> (busy && cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow #(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_data,
  input  logic             unlock,
  output logic [SEL_W-1:0] sel_active
);
  logic [SEL_W-1:0] hold_q, hold_d, act_d;

  always_comb begin
    hold_d = sel_wr ? sel_data : hold_q;
    act_d  = unlock ? hold_q : sel_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      sel_active <= '0;
    end else begin
      hold_q     <= hold_d;
      sel_active <= act_d;
    end
  end

  // R3: the active selection is frozen while the lock is in force
  a_r3_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |=> $stable(sel_active));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int SEL_W      = 5,
  parameter int FIRST_HALF = 50,
  parameter int FIRST_SH   = 27,
  parameter int NORM_HALF  = 31,
  parameter int NORM_SH    = 7,
  parameter int AUTO_HALF  = 32,
  parameter int AUTO_SH    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_data,
  input  logic             start_wr,
  input  logic             auto_en,
  input  logic             free_run,
  input  logic             trig,
  input  logic             flag_clr,
  output logic             adc_clk,
  output logic [SEL_W-1:0] sel_active,
  output logic             busy,
  output logic             sample_hold,
  output logic             result_latch,
  output logic             done_flag,
  output logic             psc_rst,
  output logic             first_pend
);
  logic trig_go, en_rise, cpu_go, unlock, done_evt;
  logic start_pend, start_pend_d, done_d, first_d;

  adc_phase_ctl u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .trig     (trig),
    .trig_mode(auto_en && !free_run),
    .busy     (busy),
    .ph       (adc_clk),
    .trig_go  (trig_go),
    .psc_rst  (psc_rst),
    .en_rise  (en_rise)
  );

  assign cpu_go = en && start_pend && !adc_clk && !busy && !trig_go;

  adc_conv_timer #(
    .FIRST_HALF(FIRST_HALF), .FIRST_SH(FIRST_SH),
    .NORM_HALF (NORM_HALF),  .NORM_SH (NORM_SH),
    .AUTO_HALF (AUTO_HALF),  .AUTO_SH (AUTO_SH)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cpu_go    (cpu_go),
    .trig_go   (trig_go),
    .free_mode (auto_en && free_run),
    .first_pend(first_pend),
    .busy      (busy),
    .sample    (sample_hold),
    .last      (result_latch),
    .unlock    (unlock),
    .done_evt  (done_evt)
  );

  adc_sel_shadow #(.SEL_W(SEL_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (sel_wr),
    .sel_data  (sel_data),
    .unlock    (unlock),
    .sel_active(sel_active)
  );

  always_comb begin
    start_pend_d = start_pend;
    if (!en || cpu_go || trig_go) start_pend_d = 1'b0;
    else if (start_wr && !busy)   start_pend_d = 1'b1;

    done_d = done_flag;
    if (done_evt)      done_d = 1'b1;
    else if (flag_clr) done_d = 1'b0;

    first_d = first_pend;
    if (!en)           first_d = 1'b0;
    else if (en_rise)  first_d = 1'b1;
    else if (done_evt) first_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pend <= 1'b0;
      done_flag  <= 1'b0;
      first_pend <= 1'b0;
    end else begin
      start_pend <= start_pend_d;
      done_flag  <= done_d;
      first_pend <= first_d;
    end
  end

  // R10: flag is sticky until cleared
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);
  // R8: prescaler reset only in a launch cycle aligned to a high phase
  a_r8_psc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    psc_rst |-> (adc_clk && busy));
  // R13: disabling stops conversion and the converter clock
  a_r13_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !adc_clk));
  // R5: a conversion begins on a high converter phase unless free-running
  a_r5_launch_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && en) |=> (!busy || adc_clk));
endmodule

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;
  localparam int SW = 5;
  logic clk = 1'b0;
  logic rst_n, en, sel_wr, start_wr, auto_en, free_run, trig, flag_clr;
  logic [SW-1:0] sel_data;
  logic adc_clk, busy, sample_hold, result_latch, done_flag, psc_rst, first_pend;
  logic [SW-1:0] sel_active;

  int n_chk = 0, n_fail = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  adc_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sel_wr(sel_wr), .sel_data(sel_data),
    .start_wr(start_wr), .auto_en(auto_en), .free_run(free_run), .trig(trig),
    .flag_clr(flag_clr), .adc_clk(adc_clk), .sel_active(sel_active), .busy(busy),
    .sample_hold(sample_hold), .result_latch(result_latch), .done_flag(done_flag),
    .psc_rst(psc_rst), .first_pend(first_pend)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // conversion timing from the requirements
  function automatic int len_of(input int kind);
    return (kind == 2) ? 50 : (kind == 1) ? 32 : 31;
  endfunction
  function automatic int sh_of(input int kind);
    return (kind == 2) ? 27 : (kind == 1) ? 8 : 7;
  endfunction

  // reference model, advanced at each rising edge
  bit m_busy, m_ph, m_pend, m_first, m_done, m_psc, m_trq, m_enq;
  int m_cnt, m_len, m_sh;
  logic [SW-1:0] m_hold, m_act;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ph = 0; m_pend = 0; m_first = 0; m_done = 0; m_psc = 0;
      m_trq = 0; m_enq = 0; m_cnt = 0; m_len = 31; m_sh = 7; m_hold = '0; m_act = '0;
    end else begin
      bit last, unl, tgo, cgo, fgo, erise;
      int kind;
      last  = m_busy && (m_cnt == m_len - 1);
      unl   = !m_busy || (m_cnt >= m_len - 2);
      erise = en && !m_enq;
      tgo   = en && auto_en && !free_run && trig && !m_trq && !m_busy;
      cgo   = en && m_pend && !m_ph && !m_busy && !tgo;
      fgo   = en && last && auto_en && free_run;
      kind  = fgo ? 1 : m_first ? 2 : tgo ? 1 : 0;
      if (unl) m_act = m_hold;
      if (sel_wr) m_hold = sel_data;
      if (!en || cgo || tgo) m_pend = 0; else if (start_wr && !m_busy) m_pend = 1;
      if (last && en) m_done = 1; else if (flag_clr) m_done = 0;
      if (!en) m_first = 0; else if (erise) m_first = 1; else if (last) m_first = 0;
      if (!en) begin m_busy = 0; m_cnt = 0; end
      else if (cgo || tgo || fgo) begin
        m_busy = 1; m_cnt = 0; m_len = len_of(kind); m_sh = sh_of(kind);
      end else if (last) begin m_busy = 0; m_cnt = 0; end
      else if (m_busy) m_cnt++;
      m_ph  = !en ? 0 : tgo ? 1 : !m_ph;
      m_psc = tgo;
      m_trq = trig;
      m_enq = en;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      chk(busy == m_busy, "R5 busy", busy, m_busy);
      chk(adc_clk == m_ph, "R5 adc_clk", adc_clk, m_ph);
      chk(sel_active == m_act, "R2 sel_active", sel_active, m_act);
      chk(sample_hold == (m_busy && m_cnt == m_sh), "R7 sample_hold", sample_hold, m_busy && m_cnt == m_sh);
      chk(result_latch == (m_busy && m_cnt == m_len - 1), "R7 result_latch", result_latch, m_busy && m_cnt == m_len - 1);
      chk(done_flag == m_done, "R10 done_flag", done_flag, m_done);
      chk(psc_rst == m_psc, "R8 psc_rst", psc_rst, m_psc);
      chk(first_pend == m_first, "R12 first_pend", first_pend, m_first);
    end
  end

  task automatic wait_busy();
    for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
  endtask

  // current negedge is half-cycle k0 of a conversion
  task automatic measure(input int k0, input int exp_sh, input int exp_last, input string tag);
    int sh_at = -1, last_at = -1;
    for (int k = k0; k < 80; k++) begin
      if (sample_hold && sh_at < 0) sh_at = k;
      if (result_latch) begin last_at = k; break; end
      @(negedge clk);
    end
    chk(sh_at == exp_sh, {tag, " sample half-cycle"}, sh_at, exp_sh);
    chk(last_at == exp_last, {tag, " latch half-cycle"}, last_at, exp_last);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; en = 0; sel_wr = 0; sel_data = '0; start_wr = 0; auto_en = 0;
    free_run = 0; trig = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({adc_clk, busy, sample_hold, result_latch, done_flag, psc_rst, first_pend} == 0,
        "R1 outputs in reset", busy, 0);
    chk(sel_active == 0, "R1 sel_active in reset", sel_active, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && adc_clk == 0, "R1 after reset", busy, 0);
    en = 1;
    @(negedge clk);
    chk(first_pend == 1, "R12 first_pend on enable", first_pend, 1);
    sel_wr = 1; sel_data = 5'd5;
    @(negedge clk); sel_wr = 0;
    @(negedge clk);
    chk(sel_active == 5, "R2 idle follow", sel_active, 5);
    // first conversion with a locked write
    start_wr = 1; @(negedge clk); start_wr = 0;
    wait_busy();
    chk(adc_clk == 1, "R5 launch on rising phase", adc_clk, 1);
    sel_wr = 1; sel_data = 5'd9; @(negedge clk); sel_wr = 0;
    repeat (4) @(negedge clk);
    chk(sel_active == 5, "R3 frozen during conversion", sel_active, 5);
    start_wr = 1; @(negedge clk); start_wr = 0;
    measure(6, 27, 49, "R6");
    chk(sel_active == 9, "R4 resumed in last cycle", sel_active, 9);
    @(negedge clk);
    chk(first_pend == 0, "R12 cleared after first", first_pend, 1'b0);
    chk(done_flag == 1, "R10 flag set", done_flag, 1);
    repeat (20) @(negedge clk);
    chk(busy == 0, "R11 start during busy ignored", busy, 0);
    chk(done_flag == 1, "R10 flag sticky", done_flag, 1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk(done_flag == 0, "R10 flag cleared", done_flag, 0);
    // normal conversion
    start_wr = 1; @(negedge clk); start_wr = 0;
    wait_busy();
    measure(0, 7, 30, "R7");
    @(negedge clk);
    // triggered conversion with a second trigger during busy
    auto_en = 1; @(negedge clk);
    trig = 1; @(negedge clk);
    chk(busy == 1 && psc_rst == 1 && adc_clk == 1, "R8 trigger launch", psc_rst, 1);
    trig = 0; @(negedge clk);
    chk(psc_rst == 0, "R8 single pulse", psc_rst, 0);
    trig = 1; @(negedge clk);
    measure(2, 8, 31, "R8");
    @(negedge clk);
    chk(busy == 0, "R11 trigger during busy ignored", busy, 0);
    trig = 0;
    // free running
    free_run = 1; start_wr = 1; @(negedge clk); start_wr = 0;
    wait_busy();
    measure(0, 7, 30, "R7 free-run first");
    @(negedge clk);
    chk(busy == 1, "R9 immediate restart", busy, 1);
    measure(0, 8, 31, "R9");
    free_run = 0; auto_en = 0;
    @(negedge clk);
    en = 0; @(negedge clk);
    chk(busy == 0 && adc_clk == 0, "R13 disable", busy, 0);
    en = 1; @(negedge clk);
    // random phase against the model
    for (int i = 0; i < 6000; i++) begin
      sel_wr   = ($urandom % 4) == 0;
      sel_data = SW'($urandom);
      start_wr = ($urandom % 40) == 0;
      flag_clr = ($urandom % 30) == 0;
      if (($urandom % 25) == 0) trig = ~trig;
      if (($urandom % 300) == 0) auto_en = ~auto_en;
      if (($urandom % 500) == 0) free_run = ~free_run;
      en = ($urandom % 400) != 0;
      @(negedge clk);
    end
    done_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule